// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block feeds a display pipeline with frame data. It walks a chain of frame descriptors held in memory. Software gives it the address of the first descriptor. The block reads that four-word descriptor, then fetches the frame's words in bursts and pushes them into a pixel word stream. It then follows the descriptor's link to the next frame. A descriptor that links to itself shows the same frame again and again. A chain never ends on its own: the block runs until reset.

Each descriptor carries a command word. Its low field gives the frame length in 32-bit words. Its high bits ask for a start-of-frame event, ask for an end-of-frame event, and flag that the frame begins with a palette. Three enable inputs gate the start-of-frame, end-of-frame and underrun events. A two-bit burst selector sets the longest memory request.

Memory is reached through a plain request/response port. A request carries a byte address and a word count. Response words come back in order, one per cycle that `mem_rsp_valid` is high. The block never has more than one request outstanding. It issues a data request only when its output FIFO has room for every word of that request.

Top module: `dfc_fetcher`

## Requirements
- R1: After reset `busy`, `mem_req_valid`, `px_valid` and the three event outputs are low, and `frame_id`, `frame_addr` and `frame_pal` are zero.
- R2: A `start_valid` pulse while `busy` is low raises `busy` on the next cycle and then requests 4 words at `start_addr`. A `start_valid` pulse while `busy` is high is ignored.
- R3: A descriptor holds the link at byte offset 0, the frame base at offset 4, the frame ID at offset 8 and the command word at offset 12. One cycle after the fourth descriptor word is accepted, `frame_id` and `frame_addr` show that descriptor's ID and base.
- R4: A frame's words are requested from its base upward, 4 bytes per word. The total is the command word's bits [LEN_W-1:0] (bits 15:0 by default). Each burst is as long as `burst_sel` allows (0 gives 4 words, 1 gives 8, 2 or 3 give 16). The last burst is shortened to the remaining count.
- R5: An unaccepted request holds its address and length stable. A new request is issued only after every word of the previous one has arrived.
- R6: A data request is issued only when the free FIFO space is at least its length. Frame words leave on `px_data` in fetch order, with none lost or repeated.
- R7: After the last word of a frame, or right after a descriptor whose length is zero, the next request reads the descriptor at the link address. A self-linked descriptor therefore repeats its frame.
- R8: `sof_irq` pulses for one cycle, one cycle after the fourth descriptor word is accepted, when command bit 31 is set and `sof_en` is high.
- R9: `eof_irq` pulses one cycle after the last frame word is accepted when command bit 30 is set and `eof_en` is high. For a zero-length frame it pulses one cycle after the fourth descriptor word, and no data request is made.
- R10: `udr_irq` is high one cycle after a cycle in which `busy`, `px_ready` and `udr_en` were high and `px_valid` was low.
- R11: `frame_pal` shows command bit 28 of the last loaded descriptor, one cycle after its fourth word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Pulse that loads the first descriptor address |
| start_addr | input | 32 | Byte address of the first descriptor |
| burst_sel | input | 2 | Longest burst: 0 gives 4 words, 1 gives 8, 2 or 3 give 16 |
| sof_en | input | 1 | Enable for start-of-frame events |
| eof_en | input | 1 | Enable for end-of-frame events |
| udr_en | input | 1 | Enable for underrun events |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_len | output | 5 | Request length in words |
| mem_rsp_valid | input | 1 | Response word present (always accepted) |
| mem_rsp_data | input | 32 | Response word |
| px_valid | output | 1 | Frame word available |
| px_ready | input | 1 | Consumer takes the word |
| px_data | output | 32 | Frame word |
| busy | output | 1 | A chain is being walked |
| frame_id | output | 32 | ID of the last loaded descriptor |
| frame_addr | output | 32 | Base of the last loaded frame |
| frame_pal | output | 1 | Palette flag of the last loaded frame |
| sof_irq | output | 1 | Start-of-frame event pulse |
| eof_irq | output | 1 | End-of-frame event pulse |
| udr_irq | output | 1 | Output underrun event |

## Verification
The embedded assertions cover the properties that hold on every cycle. They check that a stalled request keeps its address and length, that each request length lies between one and the selected burst, that the FIFO never takes a word while full, that start-of-frame pulses never fall on adjacent cycles, and that an underrun follows a busy cycle. The order of requests along the chain, burst shortening, the way a self-link repeats a frame, zero-length frames, and the exact cycle of each event and of the descriptor outputs can only be shown by the bench. Its scenarios walk real chains under throttled memory and consumer handshakes and compare against a reference model every clock.

// File: rtl/dfc_pkg.sv
// Shared types and constants for the linked frame descriptor fetcher.
// Assumes 32-bit descriptor words and byte addressing.
package dfc_pkg;
    localparam int WORD_W      = 32;
    localparam int REQ_LEN_W   = 5;
    localparam int CMD_SOF_BIT = 31;
    localparam int CMD_EOF_BIT = 30;
    localparam int CMD_PAL_BIT = 28;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DESC_REQ,
        WS_DESC_RSP,
        WS_DATA_REQ,
        WS_DATA_RSP
    } walk_state_t;

    // Longest burst in words for a burst selector value.
    function automatic logic [REQ_LEN_W-1:0] burst_words(input logic [1:0] sel);
        case (sel)
            2'd0:    return REQ_LEN_W'(4);
            2'd1:    return REQ_LEN_W'(8);
            default: return REQ_LEN_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/dfc_word_fifo.sv
// Synchronous word FIFO between the memory responses and the pixel stream.
// Assumes the writer never pushes while full; a pop while empty is ignored.
module dfc_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_pop;

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign do_pop   = pop && !empty;
    assign pop_data = store[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R6
endmodule

// File: rtl/dfc_chain_walker.sv
// Descriptor chain walker: loads four-word descriptors, issues data bursts
// sized by the burst selector and FIFO room, and follows the link word.
// Assumes one request outstanding, in-order responses that are always
// accepted, burst_sel held stable while busy, and 6 <= LEN_W <= 28.
module dfc_chain_walker
    import dfc_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_valid,
    input  logic [WORD_W-1:0]    start_addr,
    input  logic [1:0]           burst_sel,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [WORD_W-1:0]    req_addr,
    output logic [REQ_LEN_W-1:0] req_len,
    input  logic                 rsp_valid,
    input  logic [WORD_W-1:0]    rsp_data,
    input  logic [CNT_W-1:0]     fifo_count,
    output logic                 fifo_push,
    output logic                 busy,
    output logic [WORD_W-1:0]    frame_id,
    output logic [WORD_W-1:0]    frame_addr,
    output logic                 frame_pal,
    output logic                 desc_done,
    output logic                 frame_done,
    output logic [WORD_W-1:0]    done_cmd
);
    walk_state_t          st;
    logic [WORD_W-1:0]    desc_ptr;
    logic [WORD_W-1:0]    link_q;
    logic [WORD_W-1:0]    base_q;
    logic [WORD_W-1:0]    id_q;
    logic [WORD_W-1:0]    cmd_q;
    logic [1:0]           word_idx;
    logic [LEN_W-1:0]     words_left;
    logic [REQ_LEN_W-1:0] burst_left;
    logic [WORD_W-1:0]    data_ptr;

    logic [REQ_LEN_W-1:0] burst_max;
    logic [REQ_LEN_W-1:0] burst_len;
    logic [CNT_W-1:0]     fifo_room;
    logic                 room_ok;
    logic [LEN_W-1:0]     new_len;

    // Burst length for the next data request: full burst or what remains.
    always_comb begin
        burst_max = burst_words(burst_sel);
        burst_len = (words_left < LEN_W'(burst_max)) ? words_left[REQ_LEN_W-1:0] : burst_max;
        fifo_room = CNT_W'(FIFO_DEPTH) - fifo_count;
        room_ok   = fifo_room >= CNT_W'(burst_len);
    end

    // Request port drive from the walk state.
    always_comb begin
        req_valid = (st == WS_DESC_REQ) || ((st == WS_DATA_REQ) && room_ok);
        req_addr  = (st == WS_DESC_REQ) ? desc_ptr : data_ptr;
        req_len   = (st == WS_DESC_REQ) ? REQ_LEN_W'(4) : burst_len;
    end

    // Strobes for the event unit and the FIFO.
    always_comb begin
        new_len    = rsp_data[LEN_W-1:0];
        desc_done  = (st == WS_DESC_RSP) && rsp_valid && (word_idx == 2'd3);
        fifo_push  = (st == WS_DATA_RSP) && rsp_valid;
        frame_done = (desc_done && (new_len == '0)) ||
                     (fifo_push && (words_left == LEN_W'(1)));
        done_cmd   = desc_done ? rsp_data : cmd_q;
        busy       = (st != WS_IDLE);
    end

    // Walk state machine and descriptor capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= WS_IDLE;
            desc_ptr   <= '0;
            link_q     <= '0;
            base_q     <= '0;
            id_q       <= '0;
            cmd_q      <= '0;
            word_idx   <= '0;
            words_left <= '0;
            burst_left <= '0;
            data_ptr   <= '0;
            frame_id   <= '0;
            frame_addr <= '0;
            frame_pal  <= 1'b0;
        end else begin
            case (st)
                WS_IDLE: begin
                    if (start_valid) begin
                        desc_ptr <= start_addr;
                        st       <= WS_DESC_REQ;
                    end
                end
                WS_DESC_REQ: begin
                    if (req_ready) begin
                        word_idx <= '0;
                        st       <= WS_DESC_RSP;
                    end
                end
                WS_DESC_RSP: begin
                    if (rsp_valid) begin
                        word_idx <= word_idx + 1'b1;
                        case (word_idx)
                            2'd0: link_q <= rsp_data;
                            2'd1: base_q <= rsp_data;
                            2'd2: id_q   <= rsp_data;
                            default: begin
                                cmd_q      <= rsp_data;
                                frame_id   <= id_q;
                                frame_addr <= base_q;
                                frame_pal  <= rsp_data[CMD_PAL_BIT];
                                words_left <= new_len;
                                data_ptr   <= base_q;
                                desc_ptr   <= link_q;
                                st         <= (new_len == '0) ? WS_DESC_REQ : WS_DATA_REQ;
                            end
                        endcase
                    end
                end
                WS_DATA_REQ: begin
                    if (req_valid && req_ready) begin
                        burst_left <= burst_len;
                        st         <= WS_DATA_RSP;
                    end
                end
                WS_DATA_RSP: begin
                    if (rsp_valid) begin
                        data_ptr   <= data_ptr + WORD_W'(4);
                        words_left <= words_left - 1'b1;
                        burst_left <= burst_left - 1'b1;
                        if (burst_left == REQ_LEN_W'(1)) begin
                            st <= (words_left == LEN_W'(1)) ? WS_DESC_REQ : WS_DATA_REQ;
                        end
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R5
    AST_REQ_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_len != '0) && (req_len <= burst_words(burst_sel)))); // R4
endmodule

// File: rtl/dfc_event_unit.sv
// Registers the start-of-frame, end-of-frame and underrun event pulses,
// gating each by its command bit and its enable input.
// Assumes desc_done and frame_done are single-cycle strobes.
module dfc_event_unit
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_done,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] done_cmd,
    input  logic              sof_en,
    input  logic              eof_en,
    input  logic              udr_en,
    input  logic              busy,
    input  logic              px_ready,
    input  logic              fifo_empty,
    output logic              sof_irq,
    output logic              eof_irq,
    output logic              udr_irq
);
    // One-cycle event pulses, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_irq <= 1'b0;
            eof_irq <= 1'b0;
            udr_irq <= 1'b0;
        end else begin
            sof_irq <= desc_done && done_cmd[CMD_SOF_BIT] && sof_en;
            eof_irq <= frame_done && done_cmd[CMD_EOF_BIT] && eof_en;
            udr_irq <= udr_en && busy && px_ready && fifo_empty;
        end
    end

    AST_SOF_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        sof_irq |=> !sof_irq); // R8
    AST_UDR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        udr_irq |-> $past(busy)); // R10
endmodule

// File: rtl/dfc_fetcher.sv
// Linked frame descriptor fetcher top: chain walker, output word FIFO and
// event unit. Assumes in-order memory responses that are always accepted.
module dfc_fetcher
    import dfc_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_valid,
    input  logic [31:0] start_addr,
    input  logic [1:0]  burst_sel,
    input  logic        sof_en,
    input  logic        eof_en,
    input  logic        udr_en,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    output logic [4:0]  mem_req_len,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        px_valid,
    input  logic        px_ready,
    output logic [31:0] px_data,
    output logic        busy,
    output logic [31:0] frame_id,
    output logic [31:0] frame_addr,
    output logic        frame_pal,
    output logic        sof_irq,
    output logic        eof_irq,
    output logic        udr_irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic              fifo_push;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CNT_W-1:0]  fifo_count;
    logic              desc_done;
    logic              frame_done;
    logic [WORD_W-1:0] done_cmd;

    assign px_valid = !fifo_empty;

    dfc_chain_walker #(
        .LEN_W      (LEN_W),
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_addr  (start_addr),
        .burst_sel   (burst_sel),
        .req_valid   (mem_req_valid),
        .req_ready   (mem_req_ready),
        .req_addr    (mem_req_addr),
        .req_len     (mem_req_len),
        .rsp_valid   (mem_rsp_valid),
        .rsp_data    (mem_rsp_data),
        .fifo_count  (fifo_count),
        .fifo_push   (fifo_push),
        .busy        (busy),
        .frame_id    (frame_id),
        .frame_addr  (frame_addr),
        .frame_pal   (frame_pal),
        .desc_done   (desc_done),
        .frame_done  (frame_done),
        .done_cmd    (done_cmd)
    );

    dfc_word_fifo #(
        .W     (WORD_W),
        .DEPTH (FIFO_DEPTH),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (mem_rsp_data),
        .pop       (px_ready),
        .pop_data  (px_data),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    dfc_event_unit u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_done  (desc_done),
        .frame_done (frame_done),
        .done_cmd   (done_cmd),
        .sof_en     (sof_en),
        .eof_en     (eof_en),
        .udr_en     (udr_en),
        .busy       (busy),
        .px_ready   (px_ready),
        .fifo_empty (fifo_empty),
        .sof_irq    (sof_irq),
        .eof_irq    (eof_irq),
        .udr_irq    (udr_irq)
    );
endmodule

// File: tb/dfc_fetcher_bench.sv
`timescale 1ns/1ps
// Bench: behavioural memory, a reference model of the chain walk, and
// per-clock comparison of every output of the fetcher.
module dfc_fetcher_bench;
    localparam int DEPTH   = 32;
    localparam int LEN_W   = 16;
    localparam int WD_CYC  = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_valid;
    logic [31:0] start_addr;
    logic [1:0]  burst_sel;
    logic        sof_en, eof_en, udr_en;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic [4:0]  mem_req_len;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        px_valid, px_ready;
    logic [31:0] px_data;
    logic        busy;
    logic [31:0] frame_id, frame_addr;
    logic        frame_pal, sof_irq, eof_irq, udr_irq;

    always #2 clk = ~clk;

    dfc_fetcher #(.LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) u_dfc_fetcher (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .burst_sel(burst_sel), .sof_en(sof_en), .eof_en(eof_en), .udr_en(udr_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data), .busy(busy),
        .frame_id(frame_id), .frame_addr(frame_addr), .frame_pal(frame_pal),
        .sof_irq(sof_irq), .eof_irq(eof_irq), .udr_irq(udr_irq)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Stimulus knobs
    int rq_per = 1, rsp_per = 1, px_per = 1;
    bit          start_pend = 0;
    logic [31:0] start_pend_addr = '0;

    // Memory and model state
    logic [31:0] mem [int unsigned];
    logic [31:0] pend[$];
    logic [31:0] expq[$];
    logic [31:0] dw [4];
    bit          m_active, m_pal;
    int          m_phase, m_wcnt, m_rem, m_out, fifo_cnt;
    logic [31:0] m_ptr, m_addr, m_cmd, m_id, m_base;
    bit          exp_sof, exp_eof, exp_udr;
    bit          prev_wait;
    logic [31:0] prev_addr;
    logic [4:0]  prev_len;

    function automatic logic [31:0] memrd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {~a[15:0], a[15:0]} ^ 32'h5A00_0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] link,
                            input logic [31:0] base, input logic [31:0] id,
                            input logic [31:0] cmd);
        mem[a] = link; mem[a + 4] = base; mem[a + 8] = id; mem[a + 12] = cmd;
    endtask

    task automatic model_clear();
        pend.delete(); expq.delete();
        m_active = 0; m_pal = 0; m_phase = 0; m_wcnt = 0; m_rem = 0; m_out = 0;
        fifo_cnt = 0; m_ptr = '0; m_addr = '0; m_cmd = '0; m_id = '0; m_base = '0;
        exp_sof = 0; exp_eof = 0; exp_udr = 0; prev_wait = 0;
        prev_addr = '0; prev_len = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_valid = 0; start_addr = '0; mem_req_ready = 0;
        mem_rsp_valid = 0; mem_rsp_data = '0; px_ready = 0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock of checking, driving and model update.
    task automatic step();
        int          bw, elen;
        logic [31:0] eaddr, d;
        bit          popped;
        @(negedge clk);
        cyc++;
        // Outputs after the last edge against the model
        chk(busy == m_active, "R2", "busy", 32'(busy), 32'(m_active));
        chk(px_valid == (expq.size() > 0), "R6", "px_valid", 32'(px_valid), 32'(expq.size() > 0));
        chk(sof_irq == exp_sof, "R8", "sof_irq", 32'(sof_irq), 32'(exp_sof));
        chk(eof_irq == exp_eof, "R9", "eof_irq", 32'(eof_irq), 32'(exp_eof));
        chk(udr_irq == exp_udr, "R10", "udr_irq", 32'(udr_irq), 32'(exp_udr));
        chk(frame_id == m_id, "R3", "frame_id", frame_id, m_id);
        chk(frame_addr == m_base, "R3", "frame_addr", frame_addr, m_base);
        chk(frame_pal == m_pal, "R11", "frame_pal", 32'(frame_pal), 32'(m_pal));
        if (prev_wait) begin
            chk(mem_req_valid && mem_req_addr == prev_addr && mem_req_len == prev_len,
                "R5", "held request addr", mem_req_addr, prev_addr);
        end
        // Drive inputs
        mem_req_ready = (rq_per == 1) || ((cyc % rq_per) != 0);
        px_ready      = (px_per == 1) || ((cyc % px_per) == 0);
        if (pend.size() > 0 && ((rsp_per == 1) || ((cyc % rsp_per) != 0))) begin
            mem_rsp_valid = 1; mem_rsp_data = pend[0];
        end else begin
            mem_rsp_valid = 0; mem_rsp_data = '0;
        end
        start_valid = start_pend; start_addr = start_pend_addr; start_pend = 0;
        #1;
        // Handshakes at the coming edge
        exp_sof = 0; exp_eof = 0;
        exp_udr = udr_en && busy && px_ready && !px_valid;
        popped  = px_valid && px_ready;
        if (start_valid && !m_active) begin
            m_active = 1; m_phase = 0; m_ptr = start_addr;
        end
        if (popped) begin
            if (expq.size() == 0) begin
                chk(0, "R6", "unexpected pixel word", px_data, 32'h0);
            end else begin
                chk(px_data == expq[0], "R6", "pixel word", px_data, expq[0]);
                void'(expq.pop_front());
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            chk(m_out == 0, "R5", "request with words outstanding", 32'(m_out), 32'h0);
            if (!m_active) begin
                chk(0, "R2", "request while idle", mem_req_addr, 32'h0);
            end else if (m_phase == 0) begin
                eaddr = m_ptr; elen = 4; m_wcnt = 0;
                chk(mem_req_addr == eaddr, "R7", "descriptor address", mem_req_addr, eaddr);
                chk(mem_req_len == 5'd4, "R3", "descriptor length", 32'(mem_req_len), 32'd4);
            end else begin
                bw = (burst_sel == 2'd0) ? 4 : (burst_sel == 2'd1) ? 8 : 16;
                elen  = (m_rem < bw) ? m_rem : bw;
                eaddr = m_addr;
                chk(mem_req_addr == eaddr, "R4", "burst address", mem_req_addr, eaddr);
                chk(int'(mem_req_len) == elen, "R4", "burst length", 32'(mem_req_len), 32'(elen));
                chk(DEPTH - fifo_cnt >= elen, "R6", "room for burst", 32'(DEPTH - fifo_cnt), 32'(elen));
            end
            for (int i = 0; i < elen; i++) pend.push_back(memrd(eaddr + 32'(4 * i)));
            m_out += elen;
        end
        if (mem_rsp_valid) begin
            d = pend.pop_front();
            m_out--;
            if (m_phase == 0) begin
                dw[m_wcnt] = d;
                m_wcnt++;
                if (m_wcnt == 4) begin
                    m_wcnt = 0;
                    m_ptr = dw[0]; m_base = dw[1]; m_addr = dw[1]; m_id = dw[2];
                    m_cmd = dw[3]; m_pal = dw[3][28]; m_rem = int'(dw[3][LEN_W-1:0]);
                    exp_sof = dw[3][31] && sof_en;
                    if (m_rem == 0) exp_eof = dw[3][30] && eof_en;
                    else m_phase = 1;
                end
            end else begin
                expq.push_back(memrd(m_addr));
                fifo_cnt++;
                m_addr = m_addr + 4;
                m_rem--;
                if (m_rem == 0) begin
                    exp_eof = m_cmd[30] && eof_en;
                    m_phase = 0;
                end
            end
        end
        if (popped) fifo_cnt--;
        prev_wait = mem_req_valid && !mem_req_ready;
        prev_addr = mem_req_addr; prev_len = mem_req_len;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic reset_check();
        @(negedge clk);
        chk(!busy && !mem_req_valid && !px_valid, "R1", "idle after reset",
            {29'h0, busy, mem_req_valid, px_valid}, 32'h0);
        chk(!sof_irq && !eof_irq && !udr_irq, "R1", "events after reset",
            {29'h0, sof_irq, eof_irq, udr_irq}, 32'h0);
        chk(frame_id == 0 && frame_addr == 0 && !frame_pal, "R1", "frame outputs after reset",
            frame_id | frame_addr, 32'h0);
    endtask

    initial begin
        rst_n = 0; burst_sel = 0; sof_en = 1; eof_en = 1; udr_en = 1;
        start_valid = 0; start_addr = 0; mem_req_ready = 0; mem_rsp_valid = 0;
        mem_rsp_data = 0; px_ready = 0;
        model_clear();
        put_desc(32'h100, 32'h200, 32'h1000, 32'h11, 32'hC000_000A);
        put_desc(32'h200, 32'h100, 32'h2000, 32'h22, 32'h5000_0003);
        put_desc(32'h300, 32'h300, 32'h3000, 32'h33, 32'hC000_0014);
        put_desc(32'h400, 32'h500, 32'h4000, 32'h44, 32'hD000_0000);
        put_desc(32'h500, 32'h400, 32'h5000, 32'h55, 32'h8000_0011);

        // Two-frame loop, burst 4, throttled request and response (R4 R7 R8 R9 R11)
        do_reset(); reset_check();
        burst_sel = 2'd0; rq_per = 3; rsp_per = 2; px_per = 1;
        start_pend = 1; start_pend_addr = 32'h100;
        run(300);

        // Self-linked frame, burst 8, slow consumer, SOF disabled, late start ignored (R2 R6 R7)
        do_reset(); reset_check();
        burst_sel = 2'd1; sof_en = 0; rq_per = 1; rsp_per = 1; px_per = 4;
        start_pend = 1; start_pend_addr = 32'h300;
        run(60);
        start_pend = 1; start_pend_addr = 32'h100;
        run(340);

        // Zero-length frame then 17 words, burst 16 (R9 R4)
        do_reset(); reset_check();
        burst_sel = 2'd2; sof_en = 1; rq_per = 1; rsp_per = 1; px_per = 1;
        start_pend = 1; start_pend_addr = 32'h400;
        run(300);

        // Selector 3 acts as 16, underrun events disabled (R4 R10)
        do_reset(); reset_check();
        burst_sel = 2'd3; udr_en = 0; rq_per = 2; rsp_per = 3; px_per = 2;
        start_pend = 1; start_pend_addr = 32'h500;
        run(300);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule